// File: doc/BRIEF.md
# Peripheral Control Register Bank

This block is a bank of 16-bit control registers that sits on a simple synchronous processor bus. The bus issues halfword or byte writes and combinational reads. Each register has its own write rule. Some registers store the data as written. The interrupt flag register clears the bits written as 1. Timer controls keep only a fixed mask of bits. DMA word counts can be written but not read back. DMA addresses are built from pairs of halfwords. A halt-control byte starts an action and stores nothing.

The block only stores state and passes it on. It drives the timer control fields and DMA counts, one-cycle strobes with a full 32-bit DMA address, halt and stop request pulses, and an interrupt request. The timers, DMA engine and power logic that use these outputs are outside the block.

Word index = byte address shifted right by one. The word map is:

| Word | Register |
|------|----------|
| 0 | display control |
| 1 | key input |
| 2 | serial mode |
| 4 | interrupt enable |
| 5 | interrupt flag |
| 6 | master enable |
| 8+c | timer control for timer c |
| 16+4c | DMA channel c source address, low half |
| 17+4c | DMA channel c source address, high half |
| 18+4c | DMA channel c destination address, low half |
| 19+4c | DMA channel c destination address, high half |
| 32+c | DMA channel c word count |

Byte address 0x50 is the halt-control byte. Every other word is plain storage.

Top module: `periph_regbank`

## Requirements
- R1: After reset, word 0 reads 0x0080, word 2 reads 0x8000 and word 1 reads 0x03FF when no key is pressed. All other words read 0x0000. irq_o, the strobes and the halt/stop pulses are low.
- R2: rdata shows the word selected by addr in the same cycle. A write takes effect at the next rising clock edge. Words with no special rule, including unmapped ones, store halfword data unchanged and read it back. No bus error exists.
- R3: A byte write (wr_byte=1) takes wdata[7:0] and places it in the byte lane picked by addr[0]: 0 selects bits 7:0 and 1 selects bits 15:8. The other byte keeps its stored value. The result then goes through that word's halfword rule.
- R4: A timer control word stores only the bits set in 0x00C7. All other bits read back as 0. The stored values appear on timer_ctrl_o, with timer c in bits 16c+15:16c.
- R5: A write to the interrupt flag word clears every bit that is 1 in the merged halfword and leaves the other bits unchanged. A byte write therefore also clears the set bits of the other lane. A bit of irq_events high in a cycle sets that flag bit at the next edge, and this set wins over a clear in the same cycle.
- R6: irq_o is high exactly when bit 0 of the master enable word is 1 and the AND of the enable and flag words is nonzero. Other master-enable bits have no effect.
- R7: Reading a DMA word-count word always returns 0x0000. The written value appears on dma_count_o, with channel c in bits 16c+15:16c.
- R8: A write to any half of a DMA source or destination address stores that half. In the cycle after the write edge it raises exactly one strobe: dma_src_stb_o[c] or dma_dst_stb_o[c]. dma_addr_o carries {high half, low half}, built from the new half and the stored other half.
- R9: A byte write to byte address 0x50 stores nothing. If wdata[7] is 0 it pulses halt_req_o for one cycle; if wdata[7] is 1 it pulses stop_req_o for one cycle. The other data bits are ignored, and halt and stop are never high together.
- R10: The key input word reads 0x03FF XOR keys_pressed, so a pressed key reads 0. Writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write this cycle |
| wr_byte | input | 1 | 1 = byte write, 0 = halfword write |
| addr | input | ADDR_W (7) | Byte address for reads and writes |
| wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| rdata | output | 16 | Read value of the addressed word |
| keys_pressed | input | KEY_W (10) | 1 = key held down |
| irq_events | input | EVT_W (16) | Event pulses that set interrupt flag bits |
| irq_o | output | 1 | Interrupt request |
| timer_ctrl_o | output | 16*NUM_TMR | Stored timer control words |
| dma_count_o | output | 16*NUM_DMA | Stored DMA word counts |
| dma_src_stb_o | output | NUM_DMA | Source address update strobe per channel |
| dma_dst_stb_o | output | NUM_DMA | Destination address update strobe per channel |
| dma_addr_o | output | 32 | Full address that goes with a strobe |
| halt_req_o | output | 1 | Halt request pulse |
| stop_req_o | output | 1 | Stop request pulse |

## Verification
The hardest case to reach from the ports is an interrupt flag that gets a hardware event and a software clear for the same bit in the same cycle. The stimulus lines up an irq_events pulse with a flag write on the same clock edge, both in directed form and through random event pulses that overlap random writes. A related case is a byte write to the flag word that wipes flag bits in the lane that was not addressed. The stimulus first sets bits in both lanes through events, then writes a single byte. The rest of the random writes, halfword and byte, are weighted toward DMA halves, timer words and the halt byte, so that pairing, masking and action-only writes occur many times.

// File: rtl/periph_regbank_pkg.sv
package periph_regbank_pkg;
    // Word indices (byte address >> 1)
    localparam int IDX_VIDCTL = 0;
    localparam int IDX_KEYS   = 1;
    localparam int IDX_SERIAL = 2;
    localparam int IDX_IE     = 4;
    localparam int IDX_IF     = 5;
    localparam int IDX_MASTER = 6;
    localparam int TMR_BASE   = 8;
    localparam int DMA_BASE   = 16;
    localparam int CNT_BASE   = 32;
    // Byte address of the halt-control byte
    localparam int HALT_BADDR = 'h50;

    localparam logic [15:0] RST_VIDCTL = 16'h0080;
    localparam logic [15:0] RST_SERIAL = 16'h8000;
    localparam logic [15:0] KEY_IDLE   = 16'h03FF;
    localparam logic [15:0] TMR_MASK   = 16'h00C7;
endpackage

// File: rtl/regbank_lane_merge.sv
module regbank_lane_merge (
    input  logic [15:0] old_i,
    input  logic [15:0] wdata_i,
    input  logic        byte_i,
    input  logic        lane_i,
    output logic [15:0] merged_o
);
    always_comb begin
        if (!byte_i)
            merged_o = wdata_i;
        else if (lane_i)
            merged_o = {wdata_i[7:0], old_i[7:0]};
        else
            merged_o = {old_i[15:8], wdata_i[7:0]};
    end
endmodule

// File: rtl/regbank_read_mux.sv
module regbank_read_mux
    import periph_regbank_pkg::*;
#(
    parameter int IDX_W   = 6,
    parameter int NUM_DMA = 4,
    parameter int KEY_W   = 10
) (
    input  logic [(1<<IDX_W)-1:0][15:0] regs_i,
    input  logic [IDX_W-1:0]            ridx_i,
    input  logic [KEY_W-1:0]            keys_i,
    output logic [15:0]                 rdata_o
);
    logic is_cnt;
    assign is_cnt = (int'(ridx_i) >= CNT_BASE) && (int'(ridx_i) < CNT_BASE + NUM_DMA);

    always_comb begin
        if (int'(ridx_i) == IDX_KEYS)
            rdata_o = KEY_IDLE ^ 16'(keys_i);
        else if (is_cnt)
            rdata_o = '0;
        else
            rdata_o = regs_i[ridx_i];
    end
endmodule

// File: rtl/regbank_irq.sv
module regbank_irq (
    input  logic [15:0] enable_i,
    input  logic [15:0] flag_i,
    input  logic        master_i,
    output logic        irq_o
);
    assign irq_o = master_i && (|(enable_i & flag_i));
endmodule

// File: rtl/periph_regbank.sv
module periph_regbank
    import periph_regbank_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int NUM_TMR = 4,
    parameter int NUM_DMA = 4,
    parameter int KEY_W   = 10,
    parameter int EVT_W   = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    wr_byte,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [15:0]             wdata,
    output logic [15:0]             rdata,
    input  logic [KEY_W-1:0]        keys_pressed,
    input  logic [EVT_W-1:0]        irq_events,
    output logic                    irq_o,
    output logic [NUM_TMR*16-1:0]   timer_ctrl_o,
    output logic [NUM_DMA*16-1:0]   dma_count_o,
    output logic [NUM_DMA-1:0]      dma_src_stb_o,
    output logic [NUM_DMA-1:0]      dma_dst_stb_o,
    output logic [31:0]             dma_addr_o,
    output logic                    halt_req_o,
    output logic                    stop_req_o
);
    localparam int IDX_W    = ADDR_W - 1;
    localparam int NUM_REGS = 1 << IDX_W;

    typedef struct packed {
        logic [NUM_REGS-1:0][15:0] regs;
        logic [NUM_DMA-1:0]        src_stb;
        logic [NUM_DMA-1:0]        dst_stb;
        logic [31:0]               addr_val;
        logic                      halt;
        logic                      stop;
    } state_t;

    state_t s_d, s_q;

    logic [IDX_W-1:0] widx_d;
    logic [IDX_W-1:0] pair_d;
    logic [15:0]      merged_d;
    logic             is_tmr_d;

    assign widx_d = addr[ADDR_W-1:1];
    assign pair_d = widx_d ^ IDX_W'(1);

    regbank_lane_merge u_merge (
        .old_i    (s_q.regs[widx_d]),
        .wdata_i  (wdata),
        .byte_i   (wr_byte),
        .lane_i   (addr[0]),
        .merged_o (merged_d)
    );

    always_comb begin
        is_tmr_d = 1'b0;
        for (int c = 0; c < NUM_TMR; c++)
            if (int'(widx_d) == TMR_BASE + c) is_tmr_d = 1'b1;
    end

    always_comb begin
        s_d         = s_q;
        s_d.src_stb = '0;
        s_d.dst_stb = '0;
        s_d.halt    = 1'b0;
        s_d.stop    = 1'b0;
        if (wr_en) begin
            if (wr_byte && int'(addr) == HALT_BADDR) begin
                if (wdata[7]) s_d.stop = 1'b1;
                else          s_d.halt = 1'b1;
            end else if (int'(widx_d) == IDX_KEYS) begin
                s_d.regs[widx_d] = s_q.regs[widx_d];
            end else if (int'(widx_d) == IDX_IF) begin
                s_d.regs[widx_d] = s_q.regs[widx_d] & ~merged_d;
            end else if (is_tmr_d) begin
                s_d.regs[widx_d] = merged_d & TMR_MASK;
            end else begin
                s_d.regs[widx_d] = merged_d;
                for (int c = 0; c < NUM_DMA; c++) begin
                    if (int'(widx_d[IDX_W-1:2]) == DMA_BASE / 4 + c) begin
                        if (widx_d[1]) s_d.dst_stb[c] = 1'b1;
                        else           s_d.src_stb[c] = 1'b1;
                        s_d.addr_val = widx_d[0] ? {merged_d, s_q.regs[pair_d]}
                                                 : {s_q.regs[pair_d], merged_d};
                    end
                end
            end
        end
        // Hardware events set flag bits after any clear: set wins
        s_d.regs[IDX_IF] = s_d.regs[IDX_IF] | 16'(irq_events);
    end

    function automatic state_t reset_state();
        state_t r;
        r = '0;
        r.regs[IDX_VIDCTL] = RST_VIDCTL;
        r.regs[IDX_SERIAL] = RST_SERIAL;
        r.regs[IDX_KEYS]   = KEY_IDLE;
        return r;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= reset_state();
        else        s_q <= s_d;
    end

    regbank_read_mux #(.IDX_W(IDX_W), .NUM_DMA(NUM_DMA), .KEY_W(KEY_W)) u_rmux (
        .regs_i  (s_q.regs),
        .ridx_i  (widx_d),
        .keys_i  (keys_pressed),
        .rdata_o (rdata)
    );

    regbank_irq u_irq (
        .enable_i (s_q.regs[IDX_IE]),
        .flag_i   (s_q.regs[IDX_IF]),
        .master_i (s_q.regs[IDX_MASTER][0]),
        .irq_o    (irq_o)
    );

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        assign timer_ctrl_o[g*16 +: 16] = s_q.regs[TMR_BASE + g];
    end

    for (genvar g = 0; g < NUM_DMA; g++) begin : g_cnt
        assign dma_count_o[g*16 +: 16] = s_q.regs[CNT_BASE + g];
    end

    assign dma_src_stb_o = s_q.src_stb;
    assign dma_dst_stb_o = s_q.dst_stb;
    assign dma_addr_o    = s_q.addr_val;
    assign halt_req_o    = s_q.halt;
    assign stop_req_o    = s_q.stop;
endmodule

// File: rtl/periph_regbank_chk.sv
module periph_regbank_chk
    import periph_regbank_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int NUM_DMA = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic               wr_byte,
    input logic [ADDR_W-1:0]  addr,
    input logic [15:0]        wdata,
    input logic [15:0]        rdata,
    input logic [15:0]        tmr0,
    input logic [NUM_DMA-1:0] src_stb,
    input logic [NUM_DMA-1:0] dst_stb,
    input logic               halt,
    input logic               stop
);
    logic halt_wr;
    logic cnt_rd;
    assign halt_wr = wr_en && wr_byte && (int'(addr) == HALT_BADDR);
    assign cnt_rd  = (int'(addr[ADDR_W-1:1]) >= CNT_BASE) &&
                     (int'(addr[ADDR_W-1:1]) < CNT_BASE + NUM_DMA);

    AST_HALT_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(halt && stop)); // R9
    AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (halt || stop) |-> $past(halt_wr)); // R9
    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({src_stb, dst_stb})); // R8
    AST_STB_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|{src_stb, dst_stb}) |-> $past(wr_en)); // R8
    AST_TMR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_byte && int'(addr) == 2 * TMR_BASE)
        |=> (tmr0 == ($past(wdata) & TMR_MASK))); // R4
    AST_CNT_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rd |-> (rdata == 16'h0000)); // R7
endmodule

bind periph_regbank periph_regbank_chk #(.ADDR_W(ADDR_W), .NUM_DMA(NUM_DMA)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_byte (wr_byte),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .tmr0    (timer_ctrl_o[15:0]),
    .src_stb (dma_src_stb_o),
    .dst_stb (dma_dst_stb_o),
    .halt    (halt_req_o),
    .stop    (stop_req_o)
);

// File: tb/periph_regbank_bench.sv
module periph_regbank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_byte = 1'b0;
    logic [6:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [9:0]  keys_pressed = '0;
    logic [15:0] irq_events = '0;
    logic        irq_o;
    logic [63:0] timer_ctrl_o;
    logic [63:0] dma_count_o;
    logic [3:0]  dma_src_stb_o;
    logic [3:0]  dma_dst_stb_o;
    logic [31:0] dma_addr_o;
    logic        halt_req_o;
    logic        stop_req_o;

    always #5 clk = ~clk;

    periph_regbank u_periph_regbank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_byte(wr_byte),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .keys_pressed(keys_pressed), .irq_events(irq_events), .irq_o(irq_o),
        .timer_ctrl_o(timer_ctrl_o), .dma_count_o(dma_count_o),
        .dma_src_stb_o(dma_src_stb_o), .dma_dst_stb_o(dma_dst_stb_o),
        .dma_addr_o(dma_addr_o), .halt_req_o(halt_req_o), .stop_req_o(stop_req_o)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] mdl [64];
    logic [3:0]  e_src, e_dst;
    logic [31:0] e_val;
    logic        e_halt, e_stop;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(int w);
        if (w == 1) return 16'h03FF ^ {6'b0, keys_pressed};
        if (w >= 32 && w < 36) return 16'h0000;
        return mdl[w];
    endfunction

    function automatic logic exp_irq();
        return mdl[6][0] && ((mdl[4] & mdl[5]) != 0);
    endfunction

    task automatic mdl_write(bit bm, logic [6:0] a, logic [15:0] d, logic [15:0] ev);
        int w = int'(a[6:1]);
        logic [15:0] old = mdl[w];
        logic [15:0] m = !bm ? d : (a[0] ? {d[7:0], old[7:0]} : {old[15:8], d[7:0]});
        e_src = '0; e_dst = '0; e_halt = 0; e_stop = 0;
        if (bm && a == 7'h50) begin
            if (d[7]) e_stop = 1; else e_halt = 1;
        end else if (w == 1) begin
        end else if (w == 5) begin
            mdl[5] = old & ~m;
        end else if (w >= 8 && w < 12) begin
            mdl[w] = m & 16'h00C7;
        end else begin
            mdl[w] = m;
            if (w >= 16 && w < 32) begin
                if (w[1]) e_dst[(w-16)/4] = 1; else e_src[(w-16)/4] = 1;
                e_val = w[0] ? {m, mdl[w-1]} : {mdl[w+1], m};
            end
        end
        mdl[5] = mdl[5] | ev;
    endtask

    // Drive at a falling edge, let one rising edge pass, check at the next falling edge
    task automatic do_write(bit bm, logic [6:0] a, logic [15:0] d, logic [15:0] ev);
        @(negedge clk);
        wr_en = 1; wr_byte = bm; addr = a; wdata = d; irq_events = ev;
        mdl_write(bm, a, d, ev);
        @(negedge clk);
        wr_en = 0; irq_events = '0;
        chk("R8 src strobe", 64'(dma_src_stb_o), 64'(e_src));
        chk("R8 dst strobe", 64'(dma_dst_stb_o), 64'(e_dst));
        if (e_src != 0 || e_dst != 0) chk("R8 address value", 64'(dma_addr_o), 64'(e_val));
        chk("R9 halt pulse", 64'(halt_req_o), 64'(e_halt));
        chk("R9 stop pulse", 64'(stop_req_o), 64'(e_stop));
        chk("R6 irq", 64'(irq_o), 64'(exp_irq()));
    endtask

    task automatic chk_rd(string req, logic [6:0] a);
        addr = a; #1;
        chk(req, 64'(rdata), 64'(exp_read(int'(a[6:1]))));
    endtask

    task automatic chk_outs();
        for (int c = 0; c < 4; c++) begin
            chk("R4 timer_ctrl_o", 64'(timer_ctrl_o[c*16 +: 16]), 64'(mdl[8+c]));
            chk("R7 dma_count_o", 64'(dma_count_o[c*16 +: 16]), 64'(mdl[32+c]));
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [6:0] hot [10] = '{7'h0A, 7'h10, 7'h13, 7'h20, 7'h23, 7'h3E, 7'h42, 7'h50, 7'h51, 7'h0C};
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) mdl[i] = 16'h0000;
        mdl[0] = 16'h0080; mdl[2] = 16'h8000; mdl[1] = 16'h03FF;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        for (int w = 0; w < 64; w++) chk_rd("R1 reset read", 7'(2*w));
        chk("R1 irq at reset", 64'(irq_o), 64'd0);
        chk("R1 strobes at reset", 64'({dma_src_stb_o, dma_dst_stb_o, halt_req_o, stop_req_o}), 64'd0);

        // R2 read is combinational; write lands at next edge
        @(negedge clk);
        wr_en = 1; wr_byte = 0; addr = 7'h7E; wdata = 16'hA5A5; #1;
        chk("R2 old value before edge", 64'(rdata), 64'h0000);
        mdl_write(0, 7'h7E, 16'hA5A5, 16'h0);
        @(negedge clk); wr_en = 0;
        chk_rd("R2 unmapped readback", 7'h7E);
        chk("R2 unmapped literal", 64'(rdata), 64'hA5A5);

        // R3 byte lane merge
        do_write(0, 7'h60, 16'h1122, 16'h0);
        do_write(1, 7'h61, 16'h77AB, 16'h0);
        chk_rd("R3 upper lane", 7'h60);
        chk("R3 upper literal", 64'(rdata), 64'hAB22);
        do_write(1, 7'h60, 16'hFF3C, 16'h0);
        chk_rd("R3 lower lane", 7'h60);
        chk("R3 lower literal", 64'(rdata), 64'hAB3C);

        // R4 timer mask
        do_write(0, 7'h12, 16'hFFFF, 16'h0);
        chk_rd("R4 timer masked", 7'h12);
        chk("R4 timer literal", 64'(rdata), 64'h00C7);
        do_write(1, 7'h13, 16'h00FF, 16'h0);
        chk_rd("R4 timer byte", 7'h12);
        chk_outs();

        // R5 flag W1C and set-wins
        do_write(0, 7'h3C, 16'h0, 16'h00F0);
        chk_rd("R5 events set flags", 7'h0A);
        do_write(0, 7'h0A, 16'h0030, 16'h0);
        chk_rd("R5 W1C", 7'h0A);
        chk("R5 W1C literal", 64'(rdata), 64'h00C0);
        do_write(0, 7'h0A, 16'h0040, 16'h0040);
        chk("R5 set wins", 64'(rdata), 64'(mdl[5]));
        chk_rd("R5 set wins read", 7'h0A);
        do_write(0, 7'h3C, 16'h0, 16'h8100);
        do_write(1, 7'h0A, 16'h0000, 16'h0);
        chk_rd("R5 byte clears other lane", 7'h0A);
        chk("R5 byte literal", 64'(rdata), 64'h00C0);

        // R6 interrupt output
        do_write(0, 7'h08, 16'h0080, 16'h0);
        chk("R6 master off", 64'(irq_o), 64'd0);
        do_write(0, 7'h0C, 16'h0002, 16'h0);
        chk("R6 master bit1 only", 64'(irq_o), 64'd0);
        do_write(0, 7'h0C, 16'h0001, 16'h0);
        chk("R6 irq asserted", 64'(irq_o), 64'd1);
        do_write(0, 7'h0A, 16'h0080, 16'h0);
        do_write(0, 7'h0A, 16'h0040, 16'h0);

        // R7 write-only count
        do_write(0, 7'h42, 16'hBEEF, 16'h0);
        chk_rd("R7 count reads zero", 7'h42);
        chk("R7 count output", 64'(dma_count_o[31:16]), 64'hBEEF);

        // R8 address pairing
        do_write(0, 7'h32, 16'h0800, 16'h0);
        chk("R8 hi first", 64'(dma_addr_o), 64'h0800_0000);
        do_write(0, 7'h30, 16'h1234, 16'h0);
        chk("R8 lo pairs", 64'(dma_addr_o), 64'h0800_1234);

        // R9 halt/stop
        do_write(1, 7'h50, 16'h007F, 16'h0);
        do_write(1, 7'h50, 16'h0080, 16'h0);
        chk_rd("R9 halt byte not stored", 7'h50);

        // R10 keys
        keys_pressed = 10'b00_0000_0101;
        chk_rd("R10 key read", 7'h02);
        chk("R10 key literal", 64'(rdata), 64'h03FA);
        do_write(0, 7'h02, 16'h1234, 16'h0);
        chk_rd("R10 write ignored", 7'h02);

        // Random mix
        for (int i = 0; i < 600; i++) begin
            bit bm = 1'($urandom % 2);
            logic [6:0] a = ($urandom % 2) ? 7'($urandom) : hot[$urandom % 10];
            logic [15:0] ev = ($urandom % 4 == 0) ? 16'($urandom) : 16'h0;
            keys_pressed = 10'($urandom);
            if (!bm) a[0] = 1'b0;
            do_write(bm, a, 16'($urandom), ev);
            chk_rd("R2 random readback", a);
            if (i % 50 == 0) chk_outs();
        end
        for (int w = 0; w < 64; w++) chk_rd("R2 final sweep", 7'(2*w));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule